// File: doc/BRIEF.md
# Eight-bit ALU status flag unit

This block sits beside the arithmetic path of an 8-bit processor core and produces both the data result and the condition flags for a single ALU operation. It supports add, add with carry, subtract, subtract with borrow, and left and right rotates through the carry. It also supports the three bitwise logic operations. For each operation it computes negative, signed overflow, zero, nibble (digit) carry and carry. It keeps these flags in an 8-bit status register, and the three upper bits of that register always read as zero.

The result is combinational from the operands. The status register is written on the rising clock edge. Two things must both be true for a flag to be written: its bit in the update-enable vector is high, and the selected operation defines that flag. A flag that is not written keeps its value. Carry-consuming operations take their carry from `cin_i`. In a core this input is normally tied to `status_o[0]`. On subtraction the carry and digit carry are inverted borrows, because the difference is formed as `a + ~b + carry_in`.

Top module: `alu_flags_unit`

## Requirements
- R1: While `rst_ni` is low the status register reads 0x00, and it stays 0x00 until the first clock edge after release.
- R2: The status layout is C at bit 0, DC at bit 1, Z at bit 2, OV at bit 3 and N at bit 4. Bits 7:5 always read 0.
- R3: Opcode 0 (add) gives `a+b`, and opcode 1 (add with carry) gives `a+b+cin_i`. C is 1 exactly when there is a carry out of bit 7.
- R4: Opcode 2 (subtract) gives `a-b`, and opcode 3 (subtract with borrow) gives `a-b-!cin_i`. C is 1 when no borrow occurs and 0 when a borrow occurs.
- R5: DC is the carry out of bits 3:0 for adds. For subtracts it is the inverted borrow out of bits 3:0.
- R6: For every defined opcode (0 to 8) that updates Z or N, Z is 1 only when the 8-bit result is zero, and N equals result bit 7.
- R7: For the add and subtract opcodes, OV is 1 exactly when the signed result lies outside -128..+127.
- R8: Opcode 4 rotates `{C,a}` left as 9 bits, giving result `{a[6:0],cin_i}` and C = `a[7]`. Opcode 5 rotates right, giving result `{cin_i,a[7:1]}` and C = `a[0]`. Both opcodes write only C, Z and N, and leave OV and DC unchanged.
- R9: Opcodes 6, 7 and 8 (AND, OR, XOR) write only Z and N, and leave C, DC and OV unchanged.
- R10: A flag whose bit in `upd_en_i` is 0 is not changed (the enable bits use the same layout as R2). The result output does not depend on `upd_en_i`.
- R11: The result follows the inputs within the same cycle. The status register changes only at a rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_i | input | 8 | First operand (rotated operand) |
| b_i | input | 8 | Second operand |
| op_i | input | 4 | Operation code, 0 to 8 |
| cin_i | input | 1 | Carry in for add-with-carry, subtract-with-borrow and rotates |
| upd_en_i | input | 5 | Per-flag write enables, same layout as status bits 4:0 |
| result_o | output | 8 | Combinational operation result |
| status_o | output | 8 | Registered status flags |

## Verification
The assertions check the following on every cycle: the upper status bits are zero; disabled flags hold their value; rotates preserve OV and DC; logic operations preserve C, DC and OV; Z and N agree with the previous result; and add and subtract carries agree with an operand comparison. The nibble carry, the signed overflow, the borrow-driven carry-in of subtract-with-borrow, the exact rotate bit paths, and the fact that status stays stable before the edge are shown only by the bench. The bench does this through its vector table and its directed sequences.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;
  localparam int unsigned FLAG_C    = 0;
  localparam int unsigned FLAG_DC   = 1;
  localparam int unsigned FLAG_Z    = 2;
  localparam int unsigned FLAG_OV   = 3;
  localparam int unsigned FLAG_N    = 4;
  localparam int unsigned NUM_FLAGS = 5;

  typedef logic [NUM_FLAGS-1:0] flag_vec_t;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADDC = 4'd1,
    OP_SUB  = 4'd2,
    OP_SUBB = 4'd3,
    OP_RLC  = 4'd4,
    OP_RRC  = 4'd5,
    OP_AND  = 4'd6,
    OP_OR   = 4'd7,
    OP_XOR  = 4'd8
  } alu_op_e;
endpackage

// File: rtl/alu_flags_adder.sv
module alu_flags_adder #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  input  logic             c0_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             hcout_o,
  output logic             ovf_o
);
  localparam int unsigned HALF = WIDTH / 2;

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   sum_full;
  logic [HALF:0]    sum_low;

  always_comb begin
    b_eff    = sub_i ? ~b_i : b_i;
    sum_full = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, c0_i};
    sum_low  = {1'b0, a_i[HALF-1:0]} + {1'b0, b_eff[HALF-1:0]} + {{HALF{1'b0}}, c0_i};
  end

  assign sum_o   = sum_full[WIDTH-1:0];
  assign cout_o  = sum_full[WIDTH];
  assign hcout_o = sum_low[HALF];
  // signed overflow: like-signed inputs, differently signed sum
  assign ovf_o   = (a_i[WIDTH-1] == b_eff[WIDTH-1]) && (sum_full[WIDTH-1] != a_i[WIDTH-1]);
endmodule

// File: rtl/alu_flags_core.sv
module alu_flags_core
  import alu_flags_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  alu_op_e          op_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] res_o,
  output flag_vec_t        flags_o,
  output flag_vec_t        def_o
);
  logic             is_sub, use_cin, c0;
  logic [WIDTH-1:0] sum;
  logic             cout, hcout, ovf;

  assign is_sub  = (op_i == OP_SUB) || (op_i == OP_SUBB);
  assign use_cin = (op_i == OP_ADDC) || (op_i == OP_SUBB);
  assign c0      = use_cin ? cin_i : is_sub;

  alu_flags_adder #(.WIDTH(WIDTH)) u_adder (
    .a_i     (a_i),
    .b_i     (b_i),
    .sub_i   (is_sub),
    .c0_i    (c0),
    .sum_o   (sum),
    .cout_o  (cout),
    .hcout_o (hcout),
    .ovf_o   (ovf)
  );

  logic c_new;

  always_comb begin
    res_o = a_i;
    c_new = 1'b0;
    def_o = '0;
    unique case (op_i)
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBB: begin
        res_o = sum;
        c_new = cout;
        def_o = '1;
      end
      OP_RLC: begin
        res_o = {a_i[WIDTH-2:0], cin_i};
        c_new = a_i[WIDTH-1];
        def_o[FLAG_C] = 1'b1; def_o[FLAG_Z] = 1'b1; def_o[FLAG_N] = 1'b1;
      end
      OP_RRC: begin
        res_o = {cin_i, a_i[WIDTH-1:1]};
        c_new = a_i[0];
        def_o[FLAG_C] = 1'b1; def_o[FLAG_Z] = 1'b1; def_o[FLAG_N] = 1'b1;
      end
      OP_AND: begin
        res_o = a_i & b_i;
        def_o[FLAG_Z] = 1'b1; def_o[FLAG_N] = 1'b1;
      end
      OP_OR: begin
        res_o = a_i | b_i;
        def_o[FLAG_Z] = 1'b1; def_o[FLAG_N] = 1'b1;
      end
      OP_XOR: begin
        res_o = a_i ^ b_i;
        def_o[FLAG_Z] = 1'b1; def_o[FLAG_N] = 1'b1;
      end
      default: ;
    endcase
  end

  always_comb begin
    flags_o          = '0;
    flags_o[FLAG_C]  = c_new;
    flags_o[FLAG_DC] = hcout;
    flags_o[FLAG_Z]  = (res_o == '0);
    flags_o[FLAG_OV] = ovf;
    flags_o[FLAG_N]  = res_o[WIDTH-1];
  end
endmodule

// File: rtl/alu_flags_sreg.sv
module alu_flags_sreg
  import alu_flags_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  flag_vec_t        flags_i,
  input  flag_vec_t        wr_i,
  output logic [WIDTH-1:0] status_o
);
  localparam int unsigned PAD = WIDTH - NUM_FLAGS;

  flag_vec_t q;

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    q[i] <= 1'b0;
      else if (wr_i[i]) q[i] <= flags_i[i];
    end
  end

  assign status_o = {{PAD{1'b0}}, q};
endmodule

// File: rtl/alu_flags_unit.sv
module alu_flags_unit
  import alu_flags_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [3:0]       op_i,
  input  logic             cin_i,
  input  logic [4:0]       upd_en_i,
  output logic [WIDTH-1:0] result_o,
  output logic [WIDTH-1:0] status_o
);
  flag_vec_t flags, def, wr;

  alu_flags_core #(.WIDTH(WIDTH)) u_core (
    .a_i     (a_i),
    .b_i     (b_i),
    .op_i    (alu_op_e'(op_i)),
    .cin_i   (cin_i),
    .res_o   (result_o),
    .flags_o (flags),
    .def_o   (def)
  );

  assign wr = upd_en_i & def;

  alu_flags_sreg #(.WIDTH(WIDTH)) u_sreg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .flags_i  (flags),
    .wr_i     (wr),
    .status_o (status_o)
  );
endmodule

// File: rtl/alu_flags_chk.sv
module alu_flags_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] a_i,
  input logic [7:0] b_i,
  input logic [3:0] op_i,
  input logic       cin_i,
  input logic [4:0] upd_en_i,
  input logic [7:0] result_o,
  input logic [7:0] status_o
);
  always @(posedge clk_i)
    if (!rst_ni) p_reset_clear_r1: assert (status_o == 8'h00);

  p_unimpl_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[7:5] == 3'b000);

  p_hold_disabled_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_en_i == 5'b0) |=> $stable(status_o));

  p_rot_keep_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd4 || op_i == 4'd5) |=> ($stable(status_o[3]) && $stable(status_o[1])));

  p_logic_keep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i >= 4'd6 && op_i <= 4'd8) |=> $stable({status_o[3], status_o[1], status_o[0]}));

  p_zero_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i <= 4'd8 && upd_en_i[2]) |=> (status_o[2] == ($past(result_o) == 8'h00)));

  p_neg_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i <= 4'd8 && upd_en_i[4]) |=> (status_o[4] == $past(result_o[7])));

  p_add_carry_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd0 && upd_en_i[0]) |=> (status_o[0] == $past(result_o < a_i)));

  p_sub_carry_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd2 && upd_en_i[0]) |=> (status_o[0] == $past(a_i >= b_i)));

  wire unused_ok = cin_i;
endmodule

bind alu_flags_unit alu_flags_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .a_i      (a_i),
  .b_i      (b_i),
  .op_i     (op_i),
  .cin_i    (cin_i),
  .upd_en_i (upd_en_i),
  .result_o (result_o),
  .status_o (status_o)
);

// File: tb/alu_flags_unit_bench.sv
module alu_flags_unit_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] a_i = '0, b_i = '0;
  logic [3:0] op_i = '0;
  logic       cin_i = 1'b0;
  logic [4:0] upd_en_i = '0;
  logic [7:0] result_o, status_o;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  alu_flags_unit u_alu_flags_unit (.*);

  typedef struct packed {
    logic [3:0] op;
    logic [7:0] a, b;
    logic       cin;
    logic [7:0] res, stat;
  } vec_t;

  // stat layout: N=4 OV=3 Z=2 DC=1 C=0
  localparam vec_t VEC [13] = '{
    '{4'd0, 8'h0F, 8'h01, 1'b0, 8'h10, 8'h02},  // R5 nibble carry
    '{4'd0, 8'hFF, 8'h01, 1'b0, 8'h00, 8'h07},  // R3 wrap to zero
    '{4'd0, 8'h7F, 8'h01, 1'b0, 8'h80, 8'h1A},  // R7 positive overflow
    '{4'd0, 8'h80, 8'h80, 1'b0, 8'h00, 8'h0D},  // R7 negative overflow
    '{4'd1, 8'h10, 8'h20, 1'b1, 8'h31, 8'h00},  // R3 carry in
    '{4'd1, 8'h0E, 8'h01, 1'b1, 8'h10, 8'h02},  // R5 carry in into nibble
    '{4'd2, 8'h05, 8'h03, 1'b0, 8'h02, 8'h03},  // R4 no borrow
    '{4'd2, 8'h03, 8'h05, 1'b0, 8'hFE, 8'h10},  // R4 borrow
    '{4'd2, 8'h10, 8'h01, 1'b0, 8'h0F, 8'h01},  // R5 nibble borrow
    '{4'd2, 8'h80, 8'h01, 1'b0, 8'h7F, 8'h09},  // R7 sub overflow
    '{4'd2, 8'h42, 8'h42, 1'b0, 8'h00, 8'h07},  // R6 equal operands
    '{4'd3, 8'h05, 8'h03, 1'b0, 8'h01, 8'h03},  // R4 pending borrow
    '{4'd3, 8'h00, 8'h00, 1'b0, 8'hFF, 8'h10}   // R4 borrow through
  };

  task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got 0x%02h expected 0x%02h", req, what, act, exp);
    end
  endtask

  task automatic drive(logic [3:0] op, logic [7:0] a, logic [7:0] b, logic c, logic [4:0] en);
    @(negedge clk_i);
    op_i = op; a_i = a; b_i = b; cin_i = c; upd_en_i = en;
    #1;
  endtask

  task automatic run(string req, logic [3:0] op, logic [7:0] a, logic [7:0] b, logic c,
                     logic [4:0] en, logic [7:0] exp_res, logic [7:0] exp_stat);
    drive(op, a, b, c, en);
    check(req, "result", result_o, exp_res);
    @(posedge clk_i); #1;
    check(req, "status", status_o, exp_stat);
  endtask

  initial begin
    #1;
    check("R1", "status in reset", status_o, 8'h00);
    drive(4'd0, 8'hFF, 8'h01, 1'b0, 5'h1F);
    @(posedge clk_i); #1;
    check("R1", "status held in reset", status_o, 8'h00);
    @(negedge clk_i) rst_ni = 1'b1;
    #1 check("R1", "status after release", status_o, 8'h00);

    for (int i = 0; i < 13; i++)
      run("R3 R4 R5 R6 R7 vector", VEC[i].op, VEC[i].a, VEC[i].b, VEC[i].cin, 5'h1F,
          VEC[i].res, VEC[i].stat);

    run("R2 R7 setup", 4'd0, 8'h7F, 8'h01, 1'b0, 5'h1F, 8'h80, 8'h1A);
    run("R8 rlc", 4'd4, 8'h80, 8'h00, 1'b0, 5'h1F, 8'h00, 8'h0F);
    run("R8 rrc", 4'd5, 8'h01, 8'h00, 1'b1, 5'h1F, 8'h80, 8'h1B);
    run("R9 and", 4'd6, 8'hF0, 8'h0F, 1'b0, 5'h1F, 8'h00, 8'h0F);
    run("R9 xor", 4'd8, 8'hFF, 8'h0F, 1'b0, 5'h1F, 8'hF0, 8'h1B);
    run("R9 or",  4'd7, 8'h00, 8'h00, 1'b0, 5'h1F, 8'h00, 8'h0F);
    run("R9 xor back", 4'd8, 8'h80, 8'h00, 1'b0, 5'h1F, 8'h80, 8'h1B);

    // R10: no enables, status untouched, result unaffected
    run("R10 all off", 4'd0, 8'hFF, 8'h01, 1'b0, 5'h00, 8'h00, 8'h1B);
    // R10: only C enabled; 0x00-0x01 borrows
    run("R10 only C", 4'd2, 8'h00, 8'h01, 1'b0, 5'h01, 8'hFF, 8'h1A);

    // R11: status stable between edges while inputs change
    drive(4'd0, 8'hFF, 8'h01, 1'b0, 5'h1F);
    check("R11", "result same cycle", result_o, 8'h00);
    check("R11", "status before edge", status_o, 8'h1A);
    @(posedge clk_i); #1;
    check("R11", "status after edge", status_o, 8'h07);
    check("R2", "upper bits", {5'b0, status_o[7:5]}, 8'h00);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      tests++; fails++;
      $display("FAIL R11 watchdog: got hang expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule